// File: doc/BRIEF.md
# Bitplane Raster Pixel Fetcher

This block turns six bitplanes held in an external byte-wide memory into a stream of colour indices, one pixel per clock, covering a full frame of 256 by 224 positions. The visible picture is a 192 by 184 window placed inside a fixed border that is 32 pixels wide on the left and right and 20 lines tall at the top and bottom. Border positions carry a fixed index of 16. Inside the window, every run of eight horizontal pixels is taken from one byte per plane. The block issues a single read strobe with six addresses, one per plane, and takes the six returned bytes one clock later. The bytes are then shifted out least significant bit first.

Three planes form the foreground index and three form the background index. A six-bit plane-enable mask gates each plane. Software writes this mask at any time, and the block adopts the written value only at the start of the next frame. A non-zero foreground index has priority over the background index. Each pixel leaves with a valid strobe and its x/y frame position. A palette stage further down the chip consumes the stream.

Top module: `bitplane_pixel_fetcher`

## Requirements
- R1: While rst is high, pix_valid and rd_en are 0. After rst falls, the first pixel produced is at position (0,0), and pix_valid stays high from then on.
- R2: Pixels come out in raster order, one per clock. x runs 0..255 within a line and y runs 0..223, after which the next frame begins at (0,0).
- R3: A pixel with x<32, x>=224, y<20 or y>=204 has index 16.
- R4: Each frame issues one rd_en pulse per group of 8 window pixels, in raster order. The first group's plane-0 address is 0x2C0, and each later group's address is one higher. Planes 0..2 (foreground) sit at base + k*0x2000, and background plane j (0..2) sits at base + 0x6000 + j*0x2000. The plane-k byte occupies rd_data[8k+7:8k] and must be valid on the clock after the rd_en pulse.
- R5: The window pixel at x uses bit ((x-32) mod 8) of its group's bytes, so the leftmost pixel takes bit 0.
- R6: The foreground index is 3 bits. Bit k of it equals plane k's pixel bit ANDed with mask bit k.
- R7: The background index is 3 bits. Bit j of it equals background plane j's pixel bit ANDed with mask bit 3+j.
- R8: A window pixel takes the foreground index when that index is non-zero, and otherwise takes the background index.
- R9: A mask write (mask_we with mask_wdata) takes effect from the frame after the write. The frame in progress keeps the mask it started with. The mask is 0x3F after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| mask_we | input | 1 | Write strobe for the plane-enable mask |
| mask_wdata | input | 6 | New mask; bits 0..2 foreground planes, bits 3..5 background planes |
| rd_en | output | 1 | Read strobe for one group of six plane bytes |
| rd_addr | output | 96 | Six 16-bit byte addresses, plane k in bits [16k+15:16k] |
| rd_data | input | 48 | Six returned bytes, plane k in bits [8k+7:8k], one clock after rd_en |
| pix_valid | output | 1 | Pixel strobe |
| pix_x | output | 8 | Horizontal frame position of the pixel |
| pix_y | output | 8 | Vertical frame position of the pixel |
| pix_idx | output | 5 | Colour index: 0..7 inside the window, 16 on the border |

## Verification
Several properties are checked on every cycle: the border index, the range of window indices, the step of the raster position from one pixel to the next, single-cycle read pulses with consecutive addresses, and the rule that the mask changes only at a frame boundary. Other behaviour can only be shown by the bench scenarios. These cover the exact bit picked for each pixel, the plane gating and foreground priority under three different masks (all planes, a sparse mix, background only), and a write made mid-frame being deferred to the next frame. The scoreboard predicts every pixel and every read address from an address-hashed memory pattern, so any change to bit order, offsets or plane placement produces mismatches.

// File: rtl/rbf_pkg.sv
package rbf_pkg;
  localparam int unsigned NUM_PLANES = 6;
  localparam int unsigned HALF_PLANES = NUM_PLANES / 2;
  localparam int unsigned PIX_PER_BYTE = 8;
  localparam int unsigned GRP_BITS = $clog2(PIX_PER_BYTE);

  typedef logic [HALF_PLANES-1:0] half_idx_t;

  function automatic half_idx_t pick_colour(input half_idx_t fg, input half_idx_t bg);
    return (fg != '0) ? fg : bg;
  endfunction
endpackage

// File: rtl/rbf_raster_timing.sv
module rbf_raster_timing #(
  parameter int unsigned ACT_W = 192,
  parameter int unsigned ACT_H = 184,
  parameter int unsigned BRD_X = 32,
  parameter int unsigned BRD_Y = 20,
  parameter int unsigned XW = 8,
  parameter int unsigned YW = 8
) (
  input  logic          clk,
  input  logic          rst,
  output logic [XW-1:0] hc,
  output logic [YW-1:0] vc,
  output logic          act,
  output logic          grp_start,
  output logic          frame_start
);
  import rbf_pkg::*;

  localparam int unsigned H_TOT = ACT_W + 2 * BRD_X;
  localparam int unsigned V_TOT = ACT_H + 2 * BRD_Y;
  localparam logic [XW-1:0] H_LAST = XW'(H_TOT - 1);
  localparam logic [YW-1:0] V_LAST = YW'(V_TOT - 1);
  localparam logic [XW-1:0] X_LO = XW'(BRD_X);
  localparam logic [XW-1:0] X_HI = XW'(BRD_X + ACT_W);
  localparam logic [YW-1:0] Y_LO = YW'(BRD_Y);
  localparam logic [YW-1:0] Y_HI = YW'(BRD_Y + ACT_H);

  logic [XW-1:0] hrel;

  always_ff @(posedge clk) begin
    if (rst) begin
      hc <= '0;
      vc <= '0;
    end else if (hc == H_LAST) begin
      hc <= '0;
      vc <= (vc == V_LAST) ? '0 : vc + 1'b1;
    end else begin
      hc <= hc + 1'b1;
    end
  end

  always_comb begin
    act         = (hc >= X_LO) && (hc < X_HI) && (vc >= Y_LO) && (vc < Y_HI);
    hrel        = hc - X_LO;
    grp_start   = act && (hrel[GRP_BITS-1:0] == '0);
    frame_start = (hc == '0) && (vc == '0);
  end

  // R2: the line counter wraps to zero after its last position
  assert_hcount_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (hc == H_LAST) |=> (hc == '0));
  // R2: the frame wraps back to line zero
  assert_vcount_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (hc == H_LAST && vc == V_LAST) |=> (vc == '0));
endmodule

// File: rtl/rbf_fetch_addr.sv
module rbf_fetch_addr #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] START_OFS = 16'h02C0,
  parameter logic [ADDR_W-1:0] PLANE_STRIDE = 16'h2000,
  parameter logic [ADDR_W-1:0] BG_OFS = 16'h6000
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  frame_start,
  input  logic                                  grp_start,
  output logic                                  rd_en,
  output logic [rbf_pkg::NUM_PLANES-1:0][ADDR_W-1:0] addr_q
);
  import rbf_pkg::*;

  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] last_base;
  logic              seen_fetch;

  function automatic logic [ADDR_W-1:0] plane_ofs(input int unsigned k);
    if (k < HALF_PLANES) return ADDR_W'(k) * PLANE_STRIDE;
    return BG_OFS + ADDR_W'(k - HALF_PLANES) * PLANE_STRIDE;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr   <= START_OFS;
      rd_en <= 1'b0;
    end else begin
      rd_en <= grp_start;
      if (frame_start) ptr <= START_OFS;
      else if (grp_start) ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (grp_start) begin
      for (int unsigned k = 0; k < NUM_PLANES; k++) begin
        addr_q[k] <= ptr + plane_ofs(k);
      end
    end
  end

  // checker state: previous plane-0 address that was issued
  always_ff @(posedge clk) begin
    if (rst) begin
      last_base  <= '0;
      seen_fetch <= 1'b0;
    end else if (rd_en) begin
      last_base  <= addr_q[0];
      seen_fetch <= 1'b1;
    end
  end

  // R4: a read request lasts exactly one cycle
  assert_fetch_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en);
  // R4: each fetch is either a frame restart or the next byte
  assert_fetch_step_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && seen_fetch) |-> (addr_q[0] == START_OFS || addr_q[0] == last_base + 1'b1));
endmodule

// File: rtl/rbf_mask_latch.sv
module rbf_mask_latch #(
  parameter int unsigned MW = 6,
  parameter logic [MW-1:0] MASK_RST = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [MW-1:0] wdata,
  input  logic          frame_start,
  output logic [MW-1:0] frame_mask
);
  logic [MW-1:0] pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending    <= MASK_RST;
      frame_mask <= MASK_RST;
    end else begin
      if (wr) pending <= wdata;
      if (frame_start) frame_mask <= pending;
    end
  end

  // R9: the mask in use moves only at a frame boundary
  assert_mask_frame_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(frame_mask) |-> $past(frame_start));
endmodule

// File: rtl/rbf_pixel_shifter.sv
module rbf_pixel_shifter #(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned BORDER_IDX = 16
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         in_valid,
  input  logic                                         in_act,
  input  logic                                         in_load,
  input  logic [rbf_pkg::NUM_PLANES-1:0]               mask,
  input  logic [rbf_pkg::NUM_PLANES*rbf_pkg::PIX_PER_BYTE-1:0] rd_data,
  output logic [IDX_W-1:0]                             pix_idx
);
  import rbf_pkg::*;

  logic [NUM_PLANES-1:0][PIX_PER_BYTE-1:0] sh;
  logic [NUM_PLANES-1:0]                   cur_bit;
  half_idx_t                               fg_idx;
  half_idx_t                               bg_idx;

  for (genvar k = 0; k < NUM_PLANES; k++) begin : g_plane
    logic [PIX_PER_BYTE-1:0] fresh;
    assign fresh      = rd_data[k*PIX_PER_BYTE +: PIX_PER_BYTE];
    assign cur_bit[k] = (in_load ? fresh[0] : sh[k][0]) & mask[k];

    always_ff @(posedge clk) begin
      if (rst) begin
        sh[k] <= '0;
      end else if (in_valid && in_load) begin
        sh[k] <= fresh >> 1;
      end else if (in_valid && in_act) begin
        sh[k] <= sh[k] >> 1;
      end
    end
  end

  assign fg_idx = cur_bit[HALF_PLANES-1:0];
  assign bg_idx = cur_bit[NUM_PLANES-1:HALF_PLANES];

  always_ff @(posedge clk) begin
    if (rst) pix_idx <= '0;
    else if (in_valid) begin
      pix_idx <= in_act ? IDX_W'(pick_colour(fg_idx, bg_idx)) : IDX_W'(BORDER_IDX);
    end
  end

  // R4: bytes are only consumed at window group starts
  assert_load_in_window_R4: assert property (@(posedge clk) disable iff (rst)
    in_load |-> in_act);
endmodule

// File: rtl/bitplane_pixel_fetcher.sv
module bitplane_pixel_fetcher #(
  parameter int unsigned ACT_W = 192,
  parameter int unsigned ACT_H = 184,
  parameter int unsigned BRD_X = 32,
  parameter int unsigned BRD_Y = 20,
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] START_OFS = 16'h02C0,
  parameter logic [ADDR_W-1:0] PLANE_STRIDE = 16'h2000,
  parameter logic [ADDR_W-1:0] BG_OFS = 16'h6000,
  parameter int unsigned IDX_W = 5,
  parameter int unsigned BORDER_IDX = 16,
  parameter logic [5:0] MASK_RST = 6'h3F,
  localparam int unsigned H_TOT = ACT_W + 2 * BRD_X,
  localparam int unsigned V_TOT = ACT_H + 2 * BRD_Y,
  localparam int unsigned XW = $clog2(H_TOT),
  localparam int unsigned YW = $clog2(V_TOT)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mask_we,
  input  logic [5:0]           mask_wdata,
  output logic                 rd_en,
  output logic [6*ADDR_W-1:0]  rd_addr,
  input  logic [6*8-1:0]       rd_data,
  output logic                 pix_valid,
  output logic [XW-1:0]        pix_x,
  output logic [YW-1:0]        pix_y,
  output logic [IDX_W-1:0]     pix_idx
);
  import rbf_pkg::*;

  localparam logic [XW-1:0] X_LO = XW'(BRD_X);
  localparam logic [XW-1:0] X_HI = XW'(BRD_X + ACT_W);
  localparam logic [YW-1:0] Y_LO = YW'(BRD_Y);
  localparam logic [YW-1:0] Y_HI = YW'(BRD_Y + ACT_H);
  localparam logic [XW-1:0] H_LAST = XW'(H_TOT - 1);

  logic [XW-1:0] hc;
  logic [YW-1:0] vc;
  logic          act, grp_start, frame_start;
  logic [NUM_PLANES-1:0] frame_mask;
  logic [NUM_PLANES-1:0][ADDR_W-1:0] addr_q;

  // pipeline: stage 1 aligns with the address register, stage 2 with read data
  logic          s1_v, s1_act, s1_load;
  logic [XW-1:0] s1_x;
  logic [YW-1:0] s1_y;
  logic          s2_v, s2_act, s2_load;
  logic [XW-1:0] s2_x;
  logic [YW-1:0] s2_y;

  rbf_raster_timing #(
    .ACT_W(ACT_W), .ACT_H(ACT_H), .BRD_X(BRD_X), .BRD_Y(BRD_Y), .XW(XW), .YW(YW)
  ) u_timing (
    .clk(clk), .rst(rst), .hc(hc), .vc(vc), .act(act),
    .grp_start(grp_start), .frame_start(frame_start)
  );

  rbf_mask_latch #(.MW(NUM_PLANES), .MASK_RST(MASK_RST)) u_mask (
    .clk(clk), .rst(rst), .wr(mask_we), .wdata(mask_wdata),
    .frame_start(frame_start), .frame_mask(frame_mask)
  );

  rbf_fetch_addr #(
    .ADDR_W(ADDR_W), .START_OFS(START_OFS), .PLANE_STRIDE(PLANE_STRIDE), .BG_OFS(BG_OFS)
  ) u_fetch (
    .clk(clk), .rst(rst), .frame_start(frame_start), .grp_start(grp_start),
    .rd_en(rd_en), .addr_q(addr_q)
  );

  assign rd_addr = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0; s1_act <= 1'b0; s1_load <= 1'b0; s1_x <= '0; s1_y <= '0;
      s2_v <= 1'b0; s2_act <= 1'b0; s2_load <= 1'b0; s2_x <= '0; s2_y <= '0;
      pix_valid <= 1'b0; pix_x <= '0; pix_y <= '0;
    end else begin
      s1_v <= 1'b1;  s1_act <= act;    s1_load <= grp_start; s1_x <= hc;   s1_y <= vc;
      s2_v <= s1_v;  s2_act <= s1_act; s2_load <= s1_load;   s2_x <= s1_x; s2_y <= s1_y;
      pix_valid <= s2_v; pix_x <= s2_x; pix_y <= s2_y;
    end
  end

  rbf_pixel_shifter #(.IDX_W(IDX_W), .BORDER_IDX(BORDER_IDX)) u_shift (
    .clk(clk), .rst(rst), .in_valid(s2_v), .in_act(s2_act), .in_load(s2_load),
    .mask(frame_mask), .rd_data(rd_data), .pix_idx(pix_idx)
  );

  // R1: nothing is produced or requested while held in reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!pix_valid && !rd_en));
  // R3: border positions carry the fixed index
  assert_border_index_R3: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && (pix_x < X_LO || pix_x >= X_HI || pix_y < Y_LO || pix_y >= Y_HI))
      |-> (pix_idx == IDX_W'(BORDER_IDX)));
  // R8: window pixels stay within the 3-bit colour range
  assert_window_range_R8: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && pix_x >= X_LO && pix_x < X_HI && pix_y >= Y_LO && pix_y < Y_HI)
      |-> (pix_idx < IDX_W'(8)));
  // R2: consecutive pixels along a line step x by one
  assert_raster_step_R2: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && pix_x != H_LAST) |=> (pix_valid && pix_x == $past(pix_x) + 1'b1 && pix_y == $past(pix_y)));
endmodule

// File: tb/test_bitplane_pixel_fetcher.sv
module test_bitplane_pixel_fetcher;
  localparam int W = 256, H = 224, FRAME = W * H, NFR = 3;

  typedef struct { int x; int y; int idx; } pix_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mask_we = 1'b0;
  logic [5:0]  mask_wdata = '0;
  logic        rd_en;
  logic [95:0] rd_addr;
  logic [47:0] rd_data = '0;
  logic        pix_valid;
  logic [7:0]  pix_x, pix_y;
  logic [4:0]  pix_idx;

  int n_chk = 0, n_bad = 0, popped = 0, frame_no = 0;
  bit done = 0;
  pix_t exp_q[$];
  logic [15:0] addr_q[$];

  always #5 clk = ~clk;

  bitplane_pixel_fetcher i_bitplane_pixel_fetcher (
    .clk(clk), .rst(rst), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y), .pix_idx(pix_idx)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    logic [15:0] t;
    t = a * 16'h9E37;
    return t[15:8] ^ a[7:0];
  endfunction

  // memory model with one clock of read latency
  always @(posedge clk) begin
    if (rd_en) begin
      for (int k = 0; k < 6; k++) rd_data[k*8 +: 8] <= mem_byte(rd_addr[k*16 +: 16]);
    end
  end

  function automatic logic [15:0] plane_addr(input int base, input int k);
    if (k < 3) return 16'(base + k * 'h2000);
    return 16'(base + 'h6000 + (k - 3) * 'h2000);
  endfunction

  // driver: push the expected pixels and fetch addresses of one frame
  task automatic expect_frame(input logic [5:0] m);
    for (int y = 0; y < H; y++) begin
      for (int x = 0; x < W; x++) begin
        pix_t p;
        p.x = x; p.y = y;
        if (x < 32 || x >= 224 || y < 20 || y >= 204) p.idx = 16;   // R3
        else begin
          int base, b, fg, bg;
          base = 'h2C0 + (y - 20) * 24 + (x - 32) / 8;                // R4
          b = (x - 32) % 8;                                         // R5
          fg = 0; bg = 0;
          for (int k = 0; k < 3; k++) begin
            if (m[k] && mem_byte(plane_addr(base, k))[b]) fg |= (1 << k);          // R6
            if (m[3+k] && mem_byte(plane_addr(base, 3 + k))[b]) bg |= (1 << k);    // R7
          end
          p.idx = (fg != 0) ? fg : bg;                              // R8
          if (b == 0) addr_q.push_back(16'(base));
        end
        exp_q.push_back(p);
      end
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_mask(input logic [5:0] v);
    @(negedge clk); mask_we = 1'b1; mask_wdata = v;
    @(negedge clk); mask_we = 1'b0;
  endtask

  // monitor: pixels
  always @(negedge clk) begin
    if (!rst && pix_valid && !done) begin
      if (exp_q.size() == 0) check(1'b0, "R2 extra pixel", popped, FRAME * NFR);
      else begin
        pix_t e;
        e = exp_q.pop_front();
        check(int'(pix_x) == e.x && int'(pix_y) == e.y, "R1 R2 position",
              int'(pix_y) * 1000 + int'(pix_x), e.y * 1000 + e.x);
        if (e.idx == 16) check(int'(pix_idx) == e.idx, "R3 border index", int'(pix_idx), e.idx);
        else check(int'(pix_idx) == e.idx, "R5 R6 R7 R8 R9 window index", int'(pix_idx), e.idx);
        if (e.x == W - 1 && e.y == H - 1) frame_no++;
        popped++;
      end
    end
  end

  // monitor: read requests
  always @(negedge clk) begin
    if (!rst && rd_en && !done) begin
      if (addr_q.size() == 0) check(1'b0, "R4 extra fetch", 1, 0);
      else begin
        logic [15:0] b;
        b = addr_q.pop_front();
        for (int k = 0; k < 6; k++)
          check(rd_addr[k*16 +: 16] == plane_addr(int'(b), k), "R4 plane address",
                int'(rd_addr[k*16 +: 16]), int'(plane_addr(int'(b), k)));
      end
    end
  end

  initial begin
    expect_frame(6'h3F);   // R9: reset mask
    expect_frame(6'h0A);   // planes 1 and 3 only
    expect_frame(6'h38);   // background only
    repeat (4) begin
      @(negedge clk);
      check(pix_valid == 1'b0 && rd_en == 1'b0, "R1 reset quiet", int'(pix_valid) + 2 * int'(rd_en), 0);
    end
    rst = 1'b0;
    wait (frame_no == 0 && pix_y == 8'd100);
    write_mask(6'h0A);     // R9: deferred to frame 1
    wait (frame_no == 1 && pix_y == 8'd100);
    write_mask(6'h38);
    wait (frame_no == 2 && pix_y == 8'd100);
    write_mask(6'h07);     // R9: must not alter frame 2
    wait (popped == FRAME * NFR);
    @(negedge clk);
    done = 1;
    check(popped == FRAME * NFR, "R2 pixel count", popped, FRAME * NFR);
    check(addr_q.size() == 0, "R4 fetch count", addr_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", popped, FRAME * NFR);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule